// File: doc/BRIEF.md
# Pipelined Parallel FIR Filter

This block is a fixed-coefficient FIR filter in direct form. It takes one signed 16-bit sample on every rising clock edge and returns one signed 32-bit result on every edge. Incoming samples move through a 32-position delay line. Every position is multiplied in parallel by its own constant 11-bit signed weight. The 32 products are then summed by a binary adder tree that has a register after each level. This keeps the longest combinational path to one multiply or one two-input add.

The weights are fixed when the design is elaborated and are passed in as one packed parameter vector. No bits are dropped at any point: the tree grows one bit per level, and the final sum is exactly 32 bits wide. The output is therefore the exact convolution, with no saturation and no rounding. Reset is asynchronous and active-low. Its release passes through a two-flop synchronizer before it reaches the datapath.

Top module: `fir_parallel_pipe`

## Requirements
- R1: After every rising edge, `y_o` equals the sum over k = 0..31 of c[k] times the sample accepted k positions before the sample that is reaching the output. The sum is exact in 32-bit two's complement, with no saturation or rounding.
- R2: Full-scale inputs (-32768 and +32767) combined with extreme weights (-1024 and +1023) give exact results with no wrap-around.
- R3: Weight c[k] sits at bits [11k+10 : 11k] of the `COEFS` parameter as an 11-bit signed value. Weight c[0] multiplies the newest sample and c[31] multiplies the oldest.
- R4: The delay line advances on every edge. The new sample enters position 0 and each stored sample moves one position toward the oldest end.
- R5: A sample captured at one edge first affects `y_o` right after the 7th edge, counting the capture edge as the first. The output does not change any earlier.
- R6: While `rst_n_i` is low, `y_o` is zero at every clock edge.
- R7: After `rst_n_i` rises, the inputs presented at the next two edges are not accepted. The first sample taken is the one presented at the third edge.
- R8: A single input of value 1, surrounded by zeros, makes `y_o` show c[0], c[1], …, c[31] on consecutive cycles, then zero.
- R9: A constant input v, held for at least 39 cycles, settles `y_o` to v times the sum of all 32 weights.
- R10: Pulling `rst_n_i` low in the middle of a stream forces `y_o` to zero at once, without waiting for a clock edge.
- R11: After 39 consecutive accepted zero samples, `y_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock; every rising edge accepts one sample |
| rst_n_i | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| x_i | input | 16 | Signed input sample |
| y_o | output | 32 | Signed filtered result, 7 cycles of latency |

## Verification
Two functions can fall in the same cycle. The first is the reset release, which takes effect through the synchronizer while a nonzero sample is already on the input. The second is an asynchronous reset arriving while the adder tree still holds products from a busy stream. The bench provokes the first by presenting a nonzero value during the two edges after release, then checking that the output stays zero for the whole latency window. It provokes the second by dropping reset right after a random stream and sampling the output one time step later, before any clock edge. In both cases the result is compared with a convolution model kept in the bench, which counts accepted samples from the release edge.

// File: rtl/fir_pipe_pkg.sv
package fir_pipe_pkg;

  localparam int DEF_TAPS = 32;
  localparam int DEF_CW   = 11;

  // Triangular default weight set: a mild low-pass shape.
  function automatic logic [DEF_TAPS*DEF_CW-1:0] default_coefs();
    logic [DEF_TAPS*DEF_CW-1:0] v;
    int m;
    v = '0;
    for (int k = 0; k < DEF_TAPS; k++) begin
      m = (k < DEF_TAPS - 1 - k) ? k : DEF_TAPS - 1 - k;
      v[k*DEF_CW +: DEF_CW] = DEF_CW'((m + 1) * 60);
    end
    return v;
  endfunction

endpackage

// File: rtl/fir_rst_sync.sv
module fir_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;

endmodule

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
  parameter int NTAPS = 32,
  parameter int DW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         sample_i,
  output logic [NTAPS*DW-1:0]   taps_o
);

  logic [DW-1:0] line_q [NTAPS];
  logic [DW-1:0] line_d [NTAPS];

  always_comb begin
    line_d[0] = sample_i;
    for (int k = 1; k < NTAPS; k++) begin
      line_d[k] = line_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++) line_q[k] <= '0;
    end else begin
      for (int k = 0; k < NTAPS; k++) line_q[k] <= line_d[k];
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_flat
    assign taps_o[k*DW +: DW] = line_q[k];
  end

endmodule

// File: rtl/fir_product_bank.sv
module fir_product_bank #(
  parameter int                  NTAPS = 32,
  parameter int                  DW    = 16,
  parameter int                  CW    = 11,
  parameter logic [NTAPS*CW-1:0] COEFS = '0,
  localparam int                 PW    = DW + CW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTAPS*DW-1:0]   taps_i,
  output logic [NTAPS*PW-1:0]   prod_o
);

  logic [NTAPS*PW-1:0] prod_d;
  logic [NTAPS*PW-1:0] prod_q;

  for (genvar k = 0; k < NTAPS; k++) begin : g_mul
    localparam logic signed [CW-1:0] WEIGHT = COEFS[k*CW +: CW];
    logic signed [DW-1:0] smp;
    logic signed [PW-1:0] mul;
    assign smp = taps_i[k*DW +: DW];
    assign mul = smp * WEIGHT;
    assign prod_d[k*PW +: PW] = mul;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  assign prod_o = prod_q;

endmodule

// File: rtl/fir_sum_stage.sv
module fir_sum_stage #(
  parameter int NI = 32,
  parameter int WI = 27,
  localparam int NO = NI / 2,
  localparam int WO = WI + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NI*WI-1:0]  in_i,
  output logic [NO*WO-1:0]  sum_o
);

  logic [NO*WO-1:0] sum_d;
  logic [NO*WO-1:0] sum_q;

  for (genvar j = 0; j < NO; j++) begin : g_pair
    logic signed [WI-1:0] a;
    logic signed [WI-1:0] b;
    logic signed [WO-1:0] s;
    assign a = in_i[(2*j)*WI +: WI];
    assign b = in_i[(2*j+1)*WI +: WI];
    assign s = a + b;
    assign sum_d[j*WO +: WO] = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/fir_parallel_pipe.sv
module fir_parallel_pipe #(
  parameter int                  NTAPS = 32,
  parameter int                  DW    = 16,
  parameter int                  CW    = 11,
  parameter int                  OW    = 32,
  parameter logic [NTAPS*CW-1:0] COEFS = fir_pipe_pkg::default_coefs()
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [OW-1:0] y_o
);

  localparam int LV   = $clog2(NTAPS);
  localparam int NPAD = 1 << LV;
  localparam int PW   = DW + CW;
  localparam int SW   = PW + LV;
  localparam int LAT  = 2 + LV;

  logic                rst_n_s;
  logic [NTAPS*DW-1:0] taps_flat;
  logic [NTAPS*PW-1:0] prod_flat;
  logic [NPAD*PW-1:0]  prod_pad;
  logic [SW-1:0]       total;

  fir_rst_sync u_rst (
    .clk        (clk_i),
    .rst_n_async(rst_n_i),
    .rst_n_sync (rst_n_s)
  );

  fir_tap_line #(.NTAPS(NTAPS), .DW(DW)) u_line (
    .clk     (clk_i),
    .rst_n   (rst_n_s),
    .sample_i(x_i),
    .taps_o  (taps_flat)
  );

  fir_product_bank #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .COEFS(COEFS)) u_mul (
    .clk   (clk_i),
    .rst_n (rst_n_s),
    .taps_i(taps_flat),
    .prod_o(prod_flat)
  );

  if (NPAD > NTAPS) begin : g_pad
    assign prod_pad = {{((NPAD-NTAPS)*PW){1'b0}}, prod_flat};
  end else begin : g_nopad
    assign prod_pad = prod_flat;
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int NI = NPAD >> l;
    localparam int WI = PW + l;
    logic [(NI/2)*(WI+1)-1:0] sum_q;
    if (l == 0) begin : g_first
      fir_sum_stage #(.NI(NI), .WI(WI)) u_add (
        .clk  (clk_i),
        .rst_n(rst_n_s),
        .in_i (prod_pad),
        .sum_o(sum_q)
      );
    end else begin : g_next
      fir_sum_stage #(.NI(NI), .WI(WI)) u_add (
        .clk  (clk_i),
        .rst_n(rst_n_s),
        .in_i (g_lvl[l-1].sum_q),
        .sum_o(sum_q)
      );
    end
  end

  assign total = g_lvl[LV-1].sum_q;

  if (OW > SW) begin : g_ext
    assign y_o = {{(OW-SW){total[SW-1]}}, total};
  end else if (OW == SW) begin : g_same
    assign y_o = total;
  end else begin : g_cut
    assign y_o = total[OW-1:0];
  end

endmodule

// File: rtl/fir_parallel_pipe_chk.sv
module fir_parallel_pipe_chk #(
  parameter int NTAPS = 32,
  parameter int DW    = 16,
  parameter int OW    = 32,
  parameter int LAT   = 7
) (
  input logic                clk,
  input logic                rst_n_ext,
  input logic                rst_n,
  input logic [DW-1:0]       x_i,
  input logic [OW-1:0]       y_o,
  input logic [NTAPS*DW-1:0] taps
);

  localparam int LIM = NTAPS + LAT;
  localparam int CNW = $clog2(LIM + 1);

  logic [CNW-1:0] zero_run;
  logic [CNW-1:0] same_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_run <= CNW'(LIM);
      same_run <= '0;
    end else begin
      if (x_i != '0)                  zero_run <= '0;
      else if (zero_run != CNW'(LIM)) zero_run <= zero_run + 1'b1;
      if (x_i != taps[DW-1:0])        same_run <= '0;
      else if (same_run != CNW'(LIM)) same_run <= same_run + 1'b1;
    end
  end

  // R6
  reset_zero_chk: assert property (@(posedge clk) !rst_n_ext |-> y_o == '0);

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> taps[DW-1:0] == $past(x_i));

  // R4
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> taps[NTAPS*DW-1:DW] == $past(taps[(NTAPS-1)*DW-1:0]));

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_run == CNW'(LIM) |-> y_o == '0);

  // R9
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    same_run == CNW'(LIM) |=> $stable(y_o));

endmodule

bind fir_parallel_pipe fir_parallel_pipe_chk #(
  .NTAPS(NTAPS), .DW(DW), .OW(OW), .LAT(LAT)
) u_chk (
  .clk      (clk_i),
  .rst_n_ext(rst_n_i),
  .rst_n    (rst_n_s),
  .x_i      (x_i),
  .y_o      (y_o),
  .taps     (taps_flat)
);

// File: tb/fir_parallel_pipe_test.sv
`timescale 1ns/1ps
module fir_parallel_pipe_test;

  localparam int NT  = 32;
  localparam int DW  = 16;
  localparam int CW  = 11;
  localparam int OW  = 32;
  localparam int LAT = 7;

  function automatic int coef(int k);
    if (k == 0)  return -1024;
    if (k == NT-1) return 1023;
    return ((k * 73 + 11) % 401) - 200;
  endfunction

  function automatic logic [NT*CW-1:0] pack_coefs();
    logic [NT*CW-1:0] v;
    for (int k = 0; k < NT; k++) v[k*CW +: CW] = CW'(coef(k));
    return v;
  endfunction

  localparam logic [NT*CW-1:0] TB_COEFS = pack_coefs();

  logic                 clk;
  logic                 rst_n;
  logic signed [DW-1:0] x;
  logic signed [OW-1:0] y;

  fir_parallel_pipe #(.NTAPS(NT), .DW(DW), .CW(CW), .OW(OW), .COEFS(TB_COEFS)) uut (
    .clk_i  (clk),
    .rst_n_i(rst_n),
    .x_i    (x),
    .y_o    (y)
  );

  int     n_checks;
  int     n_fail;
  longint hist [NT+LAT];
  int     skip;
  bit     done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, longint act, longint expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic longint model();
    longint s = 0;
    for (int k = 0; k < NT; k++) s += longint'(coef(k)) * hist[LAT-1+k];
    return s;
  endfunction

  function automatic longint coef_sum();
    longint s = 0;
    for (int k = 0; k < NT; k++) s += coef(k);
    return s;
  endfunction

  // Drive at negedge, let one rising edge pass, return at next negedge.
  task automatic step(int v);
    x = DW'(v);
    @(posedge clk);
    for (int i = NT+LAT-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = (skip > 0) ? 0 : longint'(v);
    if (skip > 0) skip--;
    @(negedge clk);
  endtask

  task automatic clear_model();
    for (int i = 0; i < NT+LAT; i++) hist[i] = 0;
  endtask

  // Reset with a nonzero value present across the release edges.
  task automatic t_reset(int junk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 immediate clear", y, 0);
    clear_model();
    repeat (3) begin
      @(negedge clk);
      check("R6 zero while reset", y, 0);
    end
    rst_n = 1'b1;
    skip = 2;
    step(junk);
    check("R7 release edge one", y, 0);
    step(junk);
    check("R7 release edge two", y, 0);
    for (int i = 0; i < LAT + 2; i++) begin
      step(0);
      check("R7 ignored sample", y, 0);
    end
  endtask

  task automatic t_impulse();
    step(1);
    check("R5 no early output", y, 0);
    for (int i = 0; i < LAT - 2; i++) begin
      step(0);
      check("R5 no early output", y, 0);
    end
    for (int k = 0; k < NT; k++) begin
      step(0);
      check("R8 impulse weight order R3", y, coef(k));
    end
    step(0);
    check("R8 impulse tail", y, 0);
  endtask

  task automatic t_constant(int v, string req);
    for (int i = 0; i < NT + LAT; i++) step(v);
    check(req, y, longint'(v) * coef_sum());
    step(v);
    check(req, y, model());
  endtask

  task automatic t_alternate();
    for (int i = 0; i < 80; i++) begin
      step((i % 2 == 0) ? -32768 : 32767);
      check("R2 full-scale alternating", y, model());
    end
  endtask

  task automatic t_stream(int n);
    for (int i = 0; i < n; i++) begin
      int v;
      v = int'($signed(16'($urandom)));
      step(v);
      check("R1 convolution stream R4", y, model());
    end
  endtask

  task automatic t_flush();
    for (int i = 0; i < NT + LAT; i++) step(0);
    check("R11 flushed to zero", y, 0);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    skip     = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    x        = '0;
    clear_model();
    #1;
    check("R6 output at reset", y, 0);
    t_reset(1234);
    t_impulse();
    t_constant(500, "R9 constant settle");
    t_constant(-32768, "R2 negative full scale");
    t_constant(32767, "R2 positive full scale");
    t_alternate();
    t_stream(300);
    t_reset(-777);
    t_stream(120);
    t_flush();
    t_stream(40);
    t_reset(31000);
    t_impulse();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule